// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

The block takes several serial TDM input streams and produces the same number of serial output streams. Each frame carries 32 eight-bit channels per stream, sent MSB first, one bit per clock. Every output channel has two control words, both written over a small CPU bus. The low word holds either a source address (stream and channel) or a message byte. The high word holds four flags: enable, message select, variable delay and an auxiliary level.

In connection mode an output channel copies the byte received on the named input stream and channel. Several outputs may name the same source, so one input can be broadcast to many outputs. In message mode the output channel sends its low word in every frame. The input bytes are stored in a double-buffered data memory. A constant-delay channel always reads the previous complete frame. A variable-delay channel reads the current frame when its source slot has already arrived. Each output byte is fetched in the channel slot before the one in which it is sent.

The CPU bus has a one-byte paging register that selects the data memory, the low connect words or the high connect words. The seven lower address bits pick the stream and the channel. Output high impedance is modelled as a data bit plus an active-high enable for each stream. A global enable input overrides every per-channel enable bit.

Top module: `tsi_switch`

## Requirements
- R1: After reset, every `ser_oe_o` and `aux_o` bit is 0, the paging register reads 0, and all connect words read 0.
- R2: When `fsync_i` is high in a cycle, the next cycle is bit 0 of channel 0. A frame lasts 256 cycles. Channel k occupies cycles 8k..8k+7 of the frame, MSB first, on both the inputs and the outputs.
- R3: In connection mode (high word bit 1 = 0), the output byte is the byte received on input stream low[6:5], channel low[4:0]. Bit 7 of the low word is ignored.
- R4: When the delay bit (high word bit 2) is 0, the source byte comes from the previous frame.
- R5: When the delay bit is 1, the source byte comes from the same frame if the source channel is below the output channel, and from the previous frame otherwise.
- R6: Any number of output channels may name the same source, and each of them receives that byte.
- R7: In message mode (high word bit 1 = 1), the output byte is the full 8-bit low word. It is sent in every frame until the CPU rewrites it.
- R8: `ser_oe_o[s]` follows the enable bit (high word bit 0) of the channel that stream s is sending, for all 8 cycles of that channel.
- R9: While `glob_oe_i` is 0, every `ser_oe_o` bit is 0.
- R10: `aux_o[s]` drives the auxiliary bit (high word bit 3) of the channel that stream s is currently sending.
- R11: Address bit 7 = 1 selects the paging register, whose value is in bits [1:0]. With bit 7 = 0, the page value picks the target: 0 = data memory (read only, writes are ignored), 1 = low connect words, 2 = high connect words (bits [3:0]), 3 = nothing (reads 0, writes are ignored). Address bits [6:5] give the stream and bits [4:0] the channel.
- R12: A CPU read of page 0 returns the byte that the addressed input stream and channel carried in the previous frame.
- R13: A connect word write that lands on the fetch edge of its channel (the end of cycle 8k-1) takes effect from the next frame. A write made earlier in that frame takes effect in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame start pulse |
| glob_oe_i | input | 1 | Global output enable, low forces all outputs off |
| ser_i | input | 4 | Serial input streams |
| ser_o | output | 4 | Serial output streams |
| ser_oe_o | output | 4 | Output enable per stream, high = driven |
| aux_o | output | 4 | Auxiliary per-channel level per stream |
| cpu_cs_i | input | 1 | CPU bus select |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 8 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data, combinational |

## Verification
Two functions can meet on the same clock edge. The first is a CPU write to a connect word on the very edge at which that word is fetched. The second is an input byte being stored in the data memory on the same edge at which a variable-delay or wrap-around fetch reads it. The first case is provoked by timing a message rewrite onto the fetch edge of channel 10, and the bench expects the old byte in that frame and the new byte in the next. A second rewrite placed earlier in a frame must show at once. The second case is covered by sources one channel below the output channel, and by channel 0 fetches that read input channel 31. Here the bench expects the byte that is being stored at that moment, checked bit by bit.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int CTL_W = 4;

  typedef struct packed {
    logic aux;
    logic var_dly;
    logic msg;
    logic en;
  } chan_ctl_t;

  typedef enum logic [1:0] {
    PG_DATA = 2'd0,
    PG_CLO  = 2'd1,
    PG_CHI  = 2'd2,
    PG_NONE = 2'd3
  } page_e;
endpackage

// File: rtl/tsi_cpu_regs.sv
module tsi_cpu_regs import tsi_pkg::*; #(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 32,
  parameter int BYTE_W      = 8,
  localparam int STRM_W = $clog2(NUM_STREAMS),
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SRC_W  = STRM_W + CH_W,
  localparam int DEPTH  = NUM_STREAMS * NUM_CH,
  localparam int ADDR_W = SRC_W + 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                cs_i,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [BYTE_W-1:0]                   wdata_i,
  output logic [BYTE_W-1:0]                   rdata_o,
  input  logic [BYTE_W-1:0]                   dm_rdata_i,
  input  logic [CH_W-1:0]                     fetch_ch_i,
  output logic [NUM_STREAMS-1:0][BYTE_W-1:0]  lo_o,
  output chan_ctl_t [NUM_STREAMS-1:0]         ctl_o
);
  page_e                          page_q;
  logic [DEPTH-1:0][BYTE_W-1:0]   lo_q;
  logic [DEPTH-1:0][CTL_W-1:0]    hi_q;
  logic                           sel_ctrl;
  logic [SRC_W-1:0]               idx;
  logic                           wr_ctrl, wr_lo, wr_hi;

  assign sel_ctrl = addr_i[ADDR_W-1];
  assign idx      = addr_i[SRC_W-1:0];
  assign wr_ctrl  = cs_i & we_i & sel_ctrl;
  assign wr_lo    = cs_i & we_i & ~sel_ctrl & (page_q == PG_CLO);
  assign wr_hi    = cs_i & we_i & ~sel_ctrl & (page_q == PG_CHI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= PG_DATA;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (wr_ctrl) page_q    <= page_e'(wdata_i[1:0]);
      if (wr_lo)   lo_q[idx] <= wdata_i;
      if (wr_hi)   hi_q[idx] <= wdata_i[CTL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[1:0] = page_q;
    end else begin
      unique case (page_q)
        PG_DATA: rdata_o = dm_rdata_i;
        PG_CLO:  rdata_o = lo_q[idx];
        PG_CHI:  rdata_o[CTL_W-1:0] = hi_q[idx];
        default: rdata_o = '0;
      endcase
    end
  end

  // one read port per output stream, all at the channel being fetched
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_port
    localparam logic [STRM_W-1:0] SI = STRM_W'(s);
    assign lo_o[s]  = lo_q[{SI, fetch_ch_i}];
    assign ctl_o[s] = chan_ctl_t'(hi_q[{SI, fetch_ch_i}]);
  end

  a_r11_empty_page_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ctrl && page_q == PG_NONE) |-> rdata_o == '0);

  a_r7_low_words_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lo |=> $stable(lo_q));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 32,
  parameter int BYTE_W      = 8,
  localparam int STRM_W = $clog2(NUM_STREAMS),
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SRC_W  = STRM_W + CH_W,
  localparam int DEPTH  = NUM_STREAMS * NUM_CH
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_STREAMS-1:0]              ser_i,
  input  logic                                wr_en_i,
  input  logic [CH_W-1:0]                     wr_ch_i,
  input  logic                                wr_bank_i,
  input  logic [NUM_STREAMS-1:0][SRC_W-1:0]   rd_src_i,
  input  logic [NUM_STREAMS-1:0]              rd_bank_i,
  output logic [NUM_STREAMS-1:0][BYTE_W-1:0]  rd_data_o,
  input  logic [SRC_W-1:0]                    cpu_idx_i,
  output logic [BYTE_W-1:0]                   cpu_data_o
);
  logic [NUM_STREAMS-1:0][BYTE_W-1:0] sh_q, byte_in;
  logic [2*DEPTH-1:0][BYTE_W-1:0]     mem_q;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_in
    assign byte_in[s] = {sh_q[s][BYTE_W-2:0], ser_i[s]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= byte_in;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (wr_en_i) begin
      for (int s = 0; s < NUM_STREAMS; s++)
        mem_q[{wr_bank_i, STRM_W'(s), wr_ch_i}] <= byte_in[s];
    end
  end

  // bypass: a slot completing on this edge is already visible to the fetch
  for (genvar p = 0; p < NUM_STREAMS; p++) begin : g_rd
    logic [STRM_W-1:0] rs;
    logic [CH_W-1:0]   rc;
    logic              hit;
    assign rs  = rd_src_i[p][SRC_W-1:CH_W];
    assign rc  = rd_src_i[p][CH_W-1:0];
    assign hit = wr_en_i && (rd_bank_i[p] == wr_bank_i) && (rc == wr_ch_i);
    assign rd_data_o[p] = hit ? byte_in[rs] : mem_q[{rd_bank_i[p], rd_src_i[p]}];
  end

  assign cpu_data_o = mem_q[{~wr_bank_i, cpu_idx_i}];

  a_r12_store_only_at_slot_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_q));
endmodule

// File: rtl/tsi_out_stage.sv
module tsi_out_stage import tsi_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  chan_ctl_t         ctl_i,
  input  logic              glob_oe_i,
  output logic              ser_o,
  output logic              oe_o,
  output logic              aux_o
);
  logic [BYTE_W-1:0] sh_q;
  logic              oe_q, aux_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      oe_q  <= 1'b0;
      aux_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= byte_i;
      oe_q  <= ctl_i.en;
      aux_q <= ctl_i.aux;
    end else begin
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign ser_o = sh_q[BYTE_W-1];
  assign oe_o  = oe_q & glob_oe_i;
  assign aux_o = aux_q;

  a_r8_enable_fixed_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(oe_q));

  a_r10_aux_fixed_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(aux_o));

  a_r9_global_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_oe_i |-> !oe_o);
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch import tsi_pkg::*; #(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 32,
  parameter int BYTE_W      = 8,
  localparam int STRM_W    = $clog2(NUM_STREAMS),
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int SRC_W     = STRM_W + CH_W,
  localparam int BIT_W     = $clog2(BYTE_W),
  localparam int FRAME_CYC = NUM_CH * BYTE_W,
  localparam int CNT_W     = $clog2(FRAME_CYC),
  localparam int ADDR_W    = SRC_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fsync_i,
  input  logic                   glob_oe_i,
  input  logic [NUM_STREAMS-1:0] ser_i,
  output logic [NUM_STREAMS-1:0] ser_o,
  output logic [NUM_STREAMS-1:0] ser_oe_o,
  output logic [NUM_STREAMS-1:0] aux_o,
  input  logic                   cpu_cs_i,
  input  logic                   cpu_we_i,
  input  logic [ADDR_W-1:0]      cpu_addr_i,
  input  logic [BYTE_W-1:0]      cpu_wdata_i,
  output logic [BYTE_W-1:0]      cpu_rdata_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             par_q;
  logic [CH_W-1:0]  slot, fetch_ch;
  logic [BIT_W-1:0] bitp;
  logic             last_bit, wrap_fetch, out_par;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else if (fsync_i || cnt_q == CNT_W'(FRAME_CYC - 1)) begin
      cnt_q <= '0;
      par_q <= ~par_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign slot       = cnt_q[CNT_W-1:BIT_W];
  assign bitp       = cnt_q[BIT_W-1:0];
  assign last_bit   = (bitp == BIT_W'(BYTE_W - 1));
  assign fetch_ch   = slot + CH_W'(1);
  assign wrap_fetch = (slot == CH_W'(NUM_CH - 1));
  // frame parity of the byte being fetched (channel 0 is fetched in the prior frame)
  assign out_par    = par_q ^ wrap_fetch;

  logic [NUM_STREAMS-1:0][BYTE_W-1:0] lo, rd_data;
  chan_ctl_t [NUM_STREAMS-1:0]        ctl;
  logic [NUM_STREAMS-1:0][SRC_W-1:0]  rd_src;
  logic [NUM_STREAMS-1:0]             rd_bank;
  logic [BYTE_W-1:0]                  dm_cpu;

  tsi_cpu_regs #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (cpu_cs_i),
    .we_i       (cpu_we_i),
    .addr_i     (cpu_addr_i),
    .wdata_i    (cpu_wdata_i),
    .rdata_o    (cpu_rdata_o),
    .dm_rdata_i (dm_cpu),
    .fetch_ch_i (fetch_ch),
    .lo_o       (lo),
    .ctl_o      (ctl)
  );

  tsi_data_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dmem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ser_i      (ser_i),
    .wr_en_i    (last_bit),
    .wr_ch_i    (slot),
    .wr_bank_i  (par_q),
    .rd_src_i   (rd_src),
    .rd_bank_i  (rd_bank),
    .rd_data_o  (rd_data),
    .cpu_idx_i  (cpu_addr_i[SRC_W-1:0]),
    .cpu_data_o (dm_cpu)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_out
    logic              use_cur;
    logic [BYTE_W-1:0] out_byte;

    assign rd_src[s]  = lo[s][SRC_W-1:0];
    // variable delay: current frame only if the source slot has already landed
    assign use_cur    = ctl[s].var_dly && (lo[s][CH_W-1:0] < fetch_ch);
    assign rd_bank[s] = use_cur ? out_par : ~out_par;
    assign out_byte   = ctl[s].msg ? lo[s] : rd_data[s];

    tsi_out_stage #(.BYTE_W(BYTE_W)) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (last_bit),
      .byte_i    (out_byte),
      .ctl_i     (ctl[s]),
      .glob_oe_i (glob_oe_i),
      .ser_o     (ser_o[s]),
      .oe_o      (ser_oe_o[s]),
      .aux_o     (aux_o[s])
    );
  end

  a_r2_fsync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> cnt_q == '0);

  a_r2_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsync_i && cnt_q == CNT_W'(FRAME_CYC - 1)) |=> (cnt_q == '0 && par_q != $past(par_q)));
endmodule

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;
  localparam int NS = 4;
  localparam int NC = 32;
  localparam int FR = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, fsync, glob_oe, cs, we;
  logic [7:0]    addr, wdata, rdata;
  logic [NS-1:0] ser_in, ser_out, oe, aux;

  int checks = 0, errors = 0;
  int pos = 0, fn = 0, rd_fn = 0;
  logic [7:0] m_lo [NS][NC];
  logic [3:0] m_hi [NS][NC];   // {aux, var, msg, en}
  bit chk_on = 0, bcast = 0, pend_on = 0;
  int chk_from = 0, pend_s = 0, pend_k = 0, pend_frame = 0;
  logic [7:0] pend_old = '0;

  tsi_switch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .glob_oe_i(glob_oe),
    .ser_i(ser_in), .ser_o(ser_out), .ser_oe_o(oe), .aux_o(aux),
    .cpu_cs_i(cs), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata)
  );

  function automatic logic [7:0] in_byte(int f, int s, int c);
    return 8'((f * 29 + s * 67 + c * 11 + 3) & 255);
  endfunction

  function automatic logic [7:0] ca(int s, int k);
    return {1'b0, 2'(s), 5'(k)};
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bench frame position, mirrors the required frame timing (R2)
  always @(posedge clk) begin
    if (!rst_n) begin
      pos <= 0; fn <= 0;
    end else if (fsync || pos == FR - 1) begin
      pos <= 0; fn <= fn + 1;
    end else begin
      pos <= pos + 1;
    end
  end

  // serial drive and output checks, away from the clock edge
  initial begin
    ser_in = '0;
    forever begin
      @(negedge clk); #1;
      if (rst_n && chk_on && fn >= chk_from) begin
        for (int s = 0; s < NS; s++) begin
          int k, b, ss, j;
          logic [7:0] lo, eb;
          logic [3:0] h;
          logic exp_oe;
          string tag;
          k = pos / 8; b = pos % 8;
          lo = (pend_on && s == pend_s && k == pend_k && fn < pend_frame) ? pend_old : m_lo[s][k];
          h = m_hi[s][k];
          exp_oe = h[0] & glob_oe;
          check(glob_oe ? "R8" : "R9", int'(oe[s]), int'(exp_oe));
          check("R10", int'(aux[s]), int'(h[3]));
          if (exp_oe) begin
            ss = int'(lo[6:5]); j = int'(lo[4:0]);
            if (h[1]) begin eb = lo; tag = "R7"; end
            else if (h[2] && j < k) begin eb = in_byte(fn, ss, j); tag = "R2/R5"; end
            else begin eb = in_byte(fn - 1, ss, j); tag = h[2] ? "R2/R5" : "R3/R4"; end
            if (bcast && s == 3) tag = "R6";
            if (pend_on && s == pend_s && k == pend_k) tag = "R13";
            check(tag, int'(ser_out[s]), int'(eb[7 - b]));
          end
        end
      end
      for (int s = 0; s < NS; s++) begin
        logic [7:0] ib;
        ib = in_byte(fn, s, pos / 8);
        ser_in[s] = ib[7 - pos % 8];
      end
    end
  end

  task automatic cpu_wr(logic [7:0] a, logic [7:0] d);
    cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic cpu_rd(logic [7:0] a, output logic [7:0] d);
    cs = 1; we = 0; addr = a;
    #1; d = rdata; rd_fn = fn;
    @(negedge clk);
    cs = 0;
  endtask

  task automatic load_cfg();
    cpu_wr(8'h80, 8'd1);
    for (int s = 0; s < NS; s++) for (int k = 0; k < NC; k++) cpu_wr(ca(s, k), m_lo[s][k]);
    cpu_wr(8'h80, 8'd2);
    for (int s = 0; s < NS; s++) for (int k = 0; k < NC; k++) cpu_wr(ca(s, k), {4'd0, m_hi[s][k]});
  endtask

  task automatic run_frames(int n);
    chk_from = fn + 2; chk_on = 1;
    while (fn < chk_from + n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    rst_n = 0; fsync = 0; glob_oe = 1; cs = 0; we = 0; addr = '0; wdata = '0;
    for (int s = 0; s < NS; s++) for (int k = 0; k < NC; k++) begin m_lo[s][k] = '0; m_hi[s][k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1", int'(oe), 0);
    check("R1", int'(aux), 0);
    @(negedge clk);
    cpu_rd(8'h80, r);          check("R1", r, 0);
    cpu_wr(8'h80, 8'd1);
    cpu_rd(ca(1, 5), r);       check("R1", r, 0);
    cpu_wr(8'h80, 8'd2);
    cpu_rd(ca(3, 31), r);      check("R1", r, 0);

    repeat (100) @(negedge clk);
    fsync = 1; @(negedge clk); fsync = 0;

    // A: constant delay permutation, some channels disabled
    for (int s = 0; s < NS; s++) for (int k = 0; k < NC; k++) begin
      m_lo[s][k] = {1'b1, 2'((s + 1) % 4), 5'(31 - k)};   // bit 7 set, ignored (R3)
      m_hi[s][k] = {1'((k ^ s) & 1), 1'b0, 1'b0, 1'(k % 7 != 3)};
    end
    load_cfg();
    run_frames(3);
    chk_on = 0;

    // B: variable delay around the output channel, stream 3 broadcast
    for (int s = 0; s < NS; s++) for (int k = 0; k < NC; k++) begin
      case (s)
        0: m_lo[s][k] = {1'b0, 2'd1, 5'(k)};
        1: m_lo[s][k] = {1'b0, 2'd2, 5'((k + 31) % 32)};
        2: m_lo[s][k] = {1'b0, 2'd3, 5'((k + 1) % 32)};
        default: m_lo[s][k] = {1'b0, 2'd0, 5'd5};
      endcase
      m_hi[s][k] = 4'b0101;
    end
    load_cfg();
    bcast = 1;
    run_frames(3);

    // CPU paging and data memory readback
    cpu_rd(ca(0, 3), r);       check("R11", r, {4'd0, m_hi[0][3]});
    cpu_wr(8'h80, 8'd1);
    cpu_rd(ca(2, 7), r);       check("R11", r, m_lo[2][7]);
    cpu_rd(8'h80, r);          check("R11", r, 1);
    cpu_wr(8'h80, 8'd0);
    cpu_rd(ca(1, 9), r);       check("R12", r, in_byte(rd_fn - 1, 1, 9));
    cpu_wr(ca(1, 9), 8'h00);
    cpu_rd(ca(1, 9), r);       check("R11", r, in_byte(rd_fn - 1, 1, 9));
    cpu_rd(ca(3, 20), r);      check("R12", r, in_byte(rd_fn - 1, 3, 20));
    cpu_wr(8'h80, 8'd3);
    cpu_rd(ca(2, 7), r);       check("R11", r, 0);
    cpu_wr(ca(2, 7), 8'hFF);
    cpu_wr(8'h80, 8'd1);
    cpu_rd(ca(2, 7), r);       check("R11", r, m_lo[2][7]);
    chk_on = 0; bcast = 0;

    // C: messages on even channels, variable delay j==k on odd ones
    for (int s = 0; s < NS; s++) for (int k = 0; k < NC; k++) begin
      if (k % 2 == 0) m_lo[s][k] = 8'((s * 40 + k * 3 + 165) & 255);
      else            m_lo[s][k] = {1'b0, 2'(3 - s), 5'(k)};
      m_hi[s][k] = {1'(k % 4 == 1), 1'(k % 2), 1'(k % 2 == 0), 1'(k % 5 != 4)};
    end
    load_cfg();
    run_frames(2);
    glob_oe = 0;
    while (fn < chk_from + 3) @(negedge clk);
    glob_oe = 1;
    while (fn < chk_from + 4) @(negedge clk);

    // R13: write on the fetch edge of channel 10, then an early write for channel 12
    cpu_wr(8'h80, 8'd1);
    while (pos != 79) @(negedge clk);
    pend_old = m_lo[0][10]; pend_s = 0; pend_k = 10; pend_frame = fn + 1; pend_on = 1;
    m_lo[0][10] = 8'h3C;
    cpu_wr(ca(0, 10), 8'h3C);
    while (pos != 91) @(negedge clk);
    m_lo[1][12] = 8'h5A;
    cpu_wr(ca(1, 12), 8'h5A);
    while (fn < pend_frame + 2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule